// File: doc/BRIEF.md
# Shared Interrupt Sense and Routing Unit

This unit conditions a bank of external shared interrupt lines and steers each one to a core. Every line first passes through a two-flop synchronizer. It then goes through its own sense stage, which can be set to a level or an edge trigger. The level can be active-high or active-low. The edge can be rising, falling or both. An edge event is held as pending until software clears it. A per-line enable mask gates the pending state. Each line is routed to one destination core through a core-select vector, and optionally to one output pin number of that core.

Software reaches the unit through a plain single-cycle register port: a write strobe, a word address, write data, and combinational read data. The address is split into a 4-bit region code (upper bits) and a word or line index (lower bits). No streaming data passes through the block, so the port has no valid/ready handshake and never back-pressures. A write completes on the clock edge where `wr_en` is high. Two dedicated regions set and clear mask bits, so no read-modify-write is needed. An edge-command region lets software raise or acknowledge an edge interrupt, for example to signal another processor.

Top module: `sirq_router`

## Requirements
- R1: After reset, every line is active-high (polarity word reads all ones), level-triggered, non-dual and masked, with nothing pending. Pin maps are invalid and the core map is 1 (core 0). Region 0 reads {8'd0, PINS, CORES-1, GROUPS-1}, and the line count equals (field[7:0]+1)*8.
- R2: A write to region 5 enables each line whose data bit is one. A write to region 6 disables each such line. Zero bits leave their lines unchanged. Region 4 reads the mask word, and mask bits change only through these two regions.
- R3: With trigger bit 0 (regions 2 and 1 hold trigger and polarity words), pending follows the synchronized input. Polarity 1 means pending when the input is high; polarity 0 means pending when the input is low.
- R4: With trigger bit 1 and dual bit 0, polarity 1 latches pending on a rising edge and polarity 0 on a falling edge. The opposite edge has no effect, and pending stays set until it is cleared.
- R5: With trigger bit 1 and dual bit 1 (region 3), both edges latch pending and polarity is ignored.
- R6: A write to region 8 with bit 31 = 1 sets edge pending of the line numbered in the low index bits; bit 31 = 0 clears it. On a level-triggered line the command has no effect. A new edge in the same cycle as a clear wins.
- R7: Region 10, indexed by line, holds a CORES-bit core-select vector. core_irq[c] is the OR over all lines of pending AND enabled AND core bit c.
- R8: Region 9, indexed by line, holds a valid flag in bit 31 and a pin number in the low bits. pin_irq[c*PINS+p] is set when an enabled pending line is routed to core c with a valid pin map equal to p. It is never set without core_irq[c].
- R9: Region 7 reads the pending word; lines beyond the count read zero.
- R10: A change on line_in reaches pending and the outputs on the third rising clock edge. A register write reaches the outputs at the edge that commits it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | LINES | Asynchronous shared interrupt lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4+clog2(LINES) | {region[3:0], index} |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| core_irq | output | CORES | Per-core interrupt request |
| pin_irq | output | CORES*PINS | Per-core, per-pin interrupt request |

## Verification
A line change driven just after a falling edge is due on the outputs after the third rising edge. The bench confirms that the outputs are still quiet after the second rising edge and asserted after the third. Register writes, including mask and edge commands, are due at the rising edge that commits them. The bench checks these at the next falling edge, where combinational reads are also sampled. A sweep covers every line in all five sense modes, with expected values derived from the mode arithmetic.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int DW = 32;
  localparam logic [3:0] RG_CONFIG = 4'd0;
  localparam logic [3:0] RG_POL    = 4'd1;
  localparam logic [3:0] RG_TRIG   = 4'd2;
  localparam logic [3:0] RG_DUAL   = 4'd3;
  localparam logic [3:0] RG_MASK   = 4'd4;
  localparam logic [3:0] RG_SMASK  = 4'd5;
  localparam logic [3:0] RG_RMASK  = 4'd6;
  localparam logic [3:0] RG_PEND   = 4'd7;
  localparam logic [3:0] RG_EDGE   = 4'd8;
  localparam logic [3:0] RG_PIN    = 4'd9;
  localparam logic [3:0] RG_CORE   = 4'd10;
  localparam int CMD_SET_BIT = 31;
  localparam int PIN_VALID_BIT = 31;
endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  logic [LINES-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= line_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/sirq_sense.sv
module sirq_sense #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl,
  input  logic [LINES-1:0] rise,
  input  logic [LINES-1:0] fall,
  input  logic [LINES-1:0] pol,
  input  logic [LINES-1:0] trig,
  input  logic [LINES-1:0] dual,
  input  logic [LINES-1:0] edge_set,
  input  logic [LINES-1:0] edge_clr,
  output logic [LINES-1:0] pend
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic event_hit;
    assign event_hit = dual[i] ? (rise[i] | fall[i])
                               : (pol[i] ? rise[i] : fall[i]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
      end else if (!trig[i]) begin
        pend[i] <= lvl[i] ~^ pol[i];
      end else if (event_hit || edge_set[i]) begin
        pend[i] <= 1'b1;
      end else if (edge_clr[i]) begin
        pend[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
  import sirq_pkg::*;
#(
  parameter int GROUPS = 1,
  parameter int LINES  = 8,
  parameter int CORES  = 2,
  parameter int PINS   = 6,
  parameter int PIN_W  = 3,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 7,
  parameter int NW     = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DW-1:0]                wdata,
  input  logic [LINES-1:0]             pend,
  output logic [DW-1:0]                rd_data,
  output logic [LINES-1:0]             pol,
  output logic [LINES-1:0]             trig,
  output logic [LINES-1:0]             dual,
  output logic [LINES-1:0]             mask,
  output logic [LINES-1:0]             pin_valid,
  output logic [LINES-1:0][PIN_W-1:0]  pin_num,
  output logic [LINES-1:0][CORES-1:0]  core_map,
  output logic [LINES-1:0]             edge_set,
  output logic [LINES-1:0]             edge_clr
);
  logic [3:0]       region;
  logic [IDX_W-1:0] idx;
  logic             idx_ok;
  logic             cmd_hit;

  assign region  = addr[ADDR_W-1 -: 4];
  assign idx     = addr[IDX_W-1:0];
  assign idx_ok  = int'(idx) < LINES;
  assign cmd_hit = wr_en && region == RG_EDGE && wdata[30:IDX_W] == '0;

  function automatic logic [DW-1:0] pick(input logic [LINES-1:0] v, input int w);
    logic [NW*DW-1:0] p;
    p = '0;
    p[LINES-1:0] = v;
    if (w >= NW) return '0;
    return p[w*DW +: DW];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol       <= '1;
      trig      <= '0;
      dual      <= '0;
      mask      <= '0;
      pin_valid <= '0;
      pin_num   <= '0;
      for (int b = 0; b < LINES; b++) core_map[b] <= CORES'(1);
    end else if (wr_en) begin
      for (int b = 0; b < LINES; b++) begin
        if (b / DW == int'(idx)) begin
          case (region)
            RG_POL:   pol[b]  <= wdata[b % DW];
            RG_TRIG:  trig[b] <= wdata[b % DW];
            RG_DUAL:  dual[b] <= wdata[b % DW];
            RG_SMASK: mask[b] <= mask[b] | wdata[b % DW];
            RG_RMASK: mask[b] <= mask[b] & ~wdata[b % DW];
            default: ;
          endcase
        end
      end
      if (idx_ok && region == RG_PIN) begin
        pin_valid[idx] <= wdata[PIN_VALID_BIT];
        pin_num[idx]   <= wdata[PIN_W-1:0];
      end
      if (idx_ok && region == RG_CORE) core_map[idx] <= wdata[CORES-1:0];
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_cmd
    assign edge_set[i] = cmd_hit &&  wdata[CMD_SET_BIT] && wdata[IDX_W-1:0] == IDX_W'(i);
    assign edge_clr[i] = cmd_hit && !wdata[CMD_SET_BIT] && wdata[IDX_W-1:0] == IDX_W'(i);
  end

  always_comb begin
    rd_data = '0;
    case (region)
      RG_CONFIG: rd_data = {8'd0, 8'(PINS), 8'(CORES - 1), 8'(GROUPS - 1)};
      RG_POL:    rd_data = pick(pol, int'(idx));
      RG_TRIG:   rd_data = pick(trig, int'(idx));
      RG_DUAL:   rd_data = pick(dual, int'(idx));
      RG_MASK:   rd_data = pick(mask, int'(idx));
      RG_PEND:   rd_data = pick(pend, int'(idx));
      RG_PIN: if (idx_ok) begin
        rd_data[PIN_VALID_BIT] = pin_valid[idx];
        rd_data[PIN_W-1:0]     = pin_num[idx];
      end
      RG_CORE: if (idx_ok) rd_data[CORES-1:0] = core_map[idx];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sirq_route.sv
module sirq_route #(
  parameter int LINES = 8,
  parameter int CORES = 2,
  parameter int PINS  = 6,
  parameter int PIN_W = 3
) (
  input  logic [LINES-1:0]            pend,
  input  logic [LINES-1:0]            mask,
  input  logic [LINES-1:0]            pin_valid,
  input  logic [LINES-1:0][PIN_W-1:0] pin_num,
  input  logic [LINES-1:0][CORES-1:0] core_map,
  output logic [CORES-1:0]            core_irq,
  output logic [CORES*PINS-1:0]       pin_irq
);
  always_comb begin
    core_irq = '0;
    pin_irq  = '0;
    for (int b = 0; b < LINES; b++) begin
      if (pend[b] && mask[b]) begin
        for (int c = 0; c < CORES; c++) begin
          if (core_map[b][c]) begin
            core_irq[c] = 1'b1;
            if (pin_valid[b] && int'(pin_num[b]) < PINS)
              pin_irq[c*PINS + int'(pin_num[b])] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sirq_router.sv
module sirq_router
  import sirq_pkg::*;
#(
  parameter int GROUPS = 1,
  parameter int CORES  = 2,
  parameter int PINS   = 6,
  localparam int LINES  = GROUPS * 8,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = 4 + IDX_W,
  localparam int PIN_W  = (PINS > 1) ? $clog2(PINS) : 1,
  localparam int NW     = (LINES + DW - 1) / DW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINES-1:0]      line_in,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rd_data,
  output logic [CORES-1:0]      core_irq,
  output logic [CORES*PINS-1:0] pin_irq
);
  logic [LINES-1:0] lvl, rise, fall;
  logic [LINES-1:0] pol, trig, dual, mask, pend;
  logic [LINES-1:0] pin_valid, edge_set, edge_clr;
  logic [LINES-1:0][PIN_W-1:0] pin_num;
  logic [LINES-1:0][CORES-1:0] core_map;

  sirq_sync #(.LINES(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  sirq_regs #(
    .GROUPS(GROUPS), .LINES(LINES), .CORES(CORES), .PINS(PINS),
    .PIN_W(PIN_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .NW(NW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pend(pend), .rd_data(rd_data), .pol(pol), .trig(trig), .dual(dual),
    .mask(mask), .pin_valid(pin_valid), .pin_num(pin_num),
    .core_map(core_map), .edge_set(edge_set), .edge_clr(edge_clr)
  );

  sirq_sense #(.LINES(LINES)) u_sense (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall),
    .pol(pol), .trig(trig), .dual(dual), .edge_set(edge_set),
    .edge_clr(edge_clr), .pend(pend)
  );

  sirq_route #(.LINES(LINES), .CORES(CORES), .PINS(PINS), .PIN_W(PIN_W)) u_route (
    .pend(pend), .mask(mask), .pin_valid(pin_valid), .pin_num(pin_num),
    .core_map(core_map), .core_irq(core_irq), .pin_irq(pin_irq)
  );
endmodule

// File: rtl/sirq_router_chk.sv
module sirq_router_chk
  import sirq_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int CORES  = 2,
  parameter int PINS   = 6,
  parameter int ADDR_W = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [LINES-1:0]      lvl,
  input logic [LINES-1:0]      pol,
  input logic [LINES-1:0]      trig,
  input logic [LINES-1:0]      mask,
  input logic [LINES-1:0]      pend,
  input logic [CORES-1:0]      core_irq,
  input logic [CORES*PINS-1:0] pin_irq
);
  logic [3:0] region;
  assign region = addr[ADDR_W-1 -: 4];

  // R2: mask moves only on set/reset-mask writes
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (region == RG_SMASK || region == RG_RMASK)) |=> $stable(mask));

  // R7: nothing enabled, nothing requested
  assert_quiet_when_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (core_irq == '0));

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !trig[i] |=> (pend[i] == ($past(lvl[i]) ~^ $past(pol[i]))));
    assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[i] && pend[i] && !(wr_en && region == RG_EDGE)) |=> pend[i]);
  end

  for (genvar c = 0; c < CORES; c++) begin : g_core
    assert_pin_needs_core_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|pin_irq[c*PINS +: PINS]) |-> core_irq[c]);
  end
endmodule

bind sirq_router sirq_router_chk #(
  .LINES(LINES), .CORES(CORES), .PINS(PINS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .lvl(lvl),
  .pol(pol), .trig(trig), .mask(mask), .pend(pend),
  .core_irq(core_irq), .pin_irq(pin_irq)
);

// File: tb/sirq_router_tb.sv
`timescale 1ns/1ps
module sirq_router_tb;
  import sirq_pkg::*;
  localparam int CORES = 2;
  localparam int PINS  = 6;
  localparam int LINES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LINES-1:0] line_in = '0;
  logic wr_en = 1'b0;
  logic [6:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [CORES-1:0] core_irq;
  logic [CORES*PINS-1:0] pin_irq;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] pol_v = 8'hFF, trig_v = 8'h00, dual_v = 8'h00;

  always #2 clk = ~clk;

  sirq_router #(.GROUPS(1), .CORES(CORES), .PINS(PINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data),
    .core_irq(core_irq), .pin_irq(pin_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] rg, input logic [2:0] ix, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = {rg, ix}; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] rg, input logic [2:0] ix, output logic [31:0] d);
    addr = {rg, ix};
    #1 d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    tick(4);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    rd(RG_CONFIG, 0, v); chk("R1 config", v, 32'h00060100);
    chk("R1 line count", (v[7:0] + 1) * 8, LINES);
    rd(RG_POL, 0, v);  chk("R1 polarity", v, 32'hFF);
    rd(RG_TRIG, 0, v); chk("R1 trigger", v, 0);
    rd(RG_DUAL, 0, v); chk("R1 dual", v, 0);
    rd(RG_MASK, 0, v); chk("R1 mask", v, 0);
    rd(RG_PEND, 0, v); chk("R9 pend idle", v, 0);
    rd(RG_CORE, 3, v); chk("R1 core map", v, 1);
    rd(RG_PIN, 5, v);  chk("R1 pin map", v, 0);
    chk("R1 core_irq", core_irq, 0);

    // R2 set/clear mask
    wr(RG_SMASK, 0, 32'h05); rd(RG_MASK, 0, v); chk("R2 set", v, 32'h05);
    wr(RG_SMASK, 0, 32'h02); rd(RG_MASK, 0, v); chk("R2 set keeps", v, 32'h07);
    wr(RG_RMASK, 0, 32'h04); rd(RG_MASK, 0, v); chk("R2 clear", v, 32'h03);
    wr(RG_RMASK, 0, 32'h00); rd(RG_MASK, 0, v); chk("R2 zero no-op", v, 32'h03);
    wr(RG_RMASK, 0, 32'hFF); rd(RG_MASK, 0, v); chk("R2 clear all", v, 32'h00);

    // Sweep: every line, modes 0 lvl-hi, 1 lvl-lo, 2 rise, 3 fall, 4 both
    for (int i = 0; i < LINES; i++) begin
      for (int m = 0; m < 5; m++) begin
        logic inact;
        logic is_edge;
        logic [1:0] cexp;
        logic [11:0] pexp;
        int c;
        c = i % 2;
        is_edge = (m >= 2);
        inact = (m == 1 || m == 3);
        cexp = 2'(1 << c);
        pexp = (m == 1) ? 12'h0 : 12'(1 << (c*PINS + i % PINS));
        pol_v[i]  = (m == 4) ? i[0] : (m == 0 || m == 2);
        trig_v[i] = is_edge;
        dual_v[i] = (m == 4);
        line_in[i] = inact;
        wr(RG_POL, 0, {24'd0, pol_v});
        wr(RG_TRIG, 0, {24'd0, trig_v});
        wr(RG_DUAL, 0, {24'd0, dual_v});
        wr(RG_CORE, 3'(i), 32'(cexp));
        wr(RG_PIN, 3'(i), (m == 1) ? 32'(i % PINS) : (32'h8000_0000 | 32'(i % PINS)));
        tick(4);
        wr(RG_EDGE, 0, 32'(i));
        wr(RG_SMASK, 0, 32'(1 << i));
        chk("R7 idle", core_irq, 0);
        // active transition: R10 latency
        line_in[i] = ~inact;
        tick(2);
        chk("R10 not yet", core_irq, 0);
        tick(1);
        chk(is_edge ? "R4 edge latch" : "R3 level active", core_irq, cexp);
        chk("R8 pin", pin_irq, pexp);
        rd(RG_PEND, 0, v); chk("R9 pend word", v, 32'(1 << i));
        // clear command: edge clears, level unaffected
        wr(RG_EDGE, 0, 32'(i));
        chk("R6 clear", core_irq, is_edge ? 2'b00 : cexp);
        // return to inactive
        line_in[i] = inact;
        tick(3);
        chk(m == 4 ? "R5 other edge" : (is_edge ? "R4 opposite edge" : "R3 level inactive"),
            core_irq, (m == 4) ? cexp : 2'b00);
        wr(RG_EDGE, 0, 32'(i));
        // set command
        wr(RG_EDGE, 0, 32'h8000_0000 | 32'(i));
        chk("R6 set", core_irq, is_edge ? cexp : 2'b00);
        wr(RG_EDGE, 0, 32'(i));
        chk("R6 clear again", core_irq, 0);
        wr(RG_RMASK, 0, 32'(1 << i));
        rd(RG_MASK, 0, v); chk("R2 mask off", v, 0);
        pol_v[i] = 1'b1; trig_v[i] = 1'b0; dual_v[i] = 1'b0;
        line_in[i] = 1'b0;
      end
    end

    // R7 masked line with pending does not request
    wr(RG_POL, 0, 32'hFF); wr(RG_TRIG, 0, 32'h00); wr(RG_DUAL, 0, 32'h00);
    line_in = 8'h10;
    tick(4);
    rd(RG_PEND, 0, v); chk("R9 pend masked", v, 32'h10);
    chk("R7 masked quiet", core_irq, 0);
    wr(RG_CORE, 4, 32'h2);
    wr(RG_SMASK, 0, 32'h10);
    chk("R7 routed core1", core_irq, 2'b10);
    line_in = 8'h00;

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule